// File: doc/BRIEF.md
# PC Card Byte/Word Access Steering

This block sits between the host side of a PC card slot and the card's internal storage. It turns the two active-low card enables, output enable, write enable, the attribute-space select, the lowest address bit and the pair-select address bits into per-segment selects and write strobes. Each segment pair holds an even-byte bank and an odd-byte bank, and a separate byte-wide attribute memory sits beside them. The block also steers data between the two 8-bit host lanes and the banks, and it raises an output enable for each lane.

Byte accesses use the low lane. An odd byte from the odd bank crosses over onto the low lane for reads, and on writes the low lane carries data into the odd bank. A high-lane-only mode reaches the odd bank directly. Word accesses use both lanes at once. The attribute space is byte-wide and even-addressed, and it uses only the low lane. All host inputs pass through one register stage, so every output follows the inputs sampled at the previous rising clock edge. The banks themselves sit outside the block.

Top module: `pc_card_steer`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, no segment select, segment write strobe, attribute select, attribute write strobe or lane output enable is active. Every output reflects the host inputs captured at the preceding rising clock edge.
- R2: With `ce_lo_n`=0, `ce_hi_n`=1, `reg_n`=1 and `a0`=0, only the even segment of the selected pair is active (seg_sel bit 2p). A read drives that bank's byte on the low lane, and a write stores the low lane in it.
- R3: With `ce_lo_n`=0, `ce_hi_n`=1, `reg_n`=1 and `a0`=1, only the odd segment (bit 2p+1) is active. A read puts the odd bank's byte on the low lane, and a write stores the low lane into the odd bank.
- R4: With `ce_lo_n`=1, `ce_hi_n`=0 and `reg_n`=1, only the odd segment is active whatever the value of `a0`. A read drives the high lane only, and a write stores the high lane into the odd bank.
- R5: With both enables low and `reg_n`=1, the even and odd segments of the pair are both active whatever the value of `a0`. The even byte uses the low lane and the odd byte uses the high lane, in both directions.
- R6: With both enables high the block is in standby: no segment, no attribute memory and no lane is enabled, and nothing is written.
- R7: While `oe_n` is high, neither lane output enable is active.
- R8: While `we_n` is low, neither lane is driven. A write strobe is issued only when `we_n` is low and `oe_n` is high. With both low, nothing is stored.
- R9: `pair` selects exactly one segment pair. At most one segment is active in the two byte modes and at most two in word mode.
- R10: With `reg_n` low and `ce_lo_n` low, only the attribute memory is selected and the high lane is never driven. An even access (`a0`=0, or word mode) reads and writes attribute data on the low lane. An odd byte access reads the constant FILL (all ones by default) and stores nothing. With `reg_n` low and `ce_lo_n` high, nothing is selected or driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_lo_n | input | 1 | Active-low enable for the low-lane byte |
| ce_hi_n | input | 1 | Active-low enable for the high-lane byte |
| oe_n | input | 1 | Active-low read output enable |
| we_n | input | 1 | Active-low write enable |
| reg_n | input | 1 | Low selects attribute space |
| a0 | input | 1 | Byte address bit, odd when high |
| pair | input | PAIR_W | Segment pair select |
| lo_in | input | LANE_W | Host low lane, write data |
| hi_in | input | LANE_W | Host high lane, write data |
| lo_out | output | LANE_W | Host low lane, read data |
| hi_out | output | LANE_W | Host high lane, read data |
| lo_oe | output | 1 | Low lane drive enable |
| hi_oe | output | 1 | High lane drive enable |
| seg_sel | output | 2*PAIRS | Segment selects, bit 2p even and 2p+1 odd of pair p |
| seg_we | output | 2*PAIRS | Segment write strobes |
| even_wdata | output | LANE_W | Write data to even banks |
| odd_wdata | output | LANE_W | Write data to odd banks |
| even_rdata | input | PAIRS*LANE_W | Even bank read data, pair p at slice p |
| odd_rdata | input | PAIRS*LANE_W | Odd bank read data, pair p at slice p |
| attr_sel | output | 1 | Attribute memory select |
| attr_we | output | 1 | Attribute memory write strobe |
| attr_wdata | output | LANE_W | Attribute write data |
| attr_rdata | input | LANE_W | Attribute read data |

## Verification
The hardest cases to reach are writes that go to the wrong place, such as an odd byte write that takes the high lane instead of the crossed-over low lane, or an odd attribute write that stores data. Such a fault shows nothing at the write itself. It only appears when the same location is read back later through another mode. The stimulus therefore writes rows in one mode and reads them back in every other mode. It then runs a long sequence of random control combinations against shadow copies of the banks, so each misplaced store appears as a read mismatch on a lane.

// File: rtl/pc_card_steer.sv
module pc_card_steer #(
  parameter int LANE_W = 8,
  parameter int PAIRS = 2,
  parameter logic [LANE_W-1:0] FILL = '1,
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int SEG_N = 2 * PAIRS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_lo_n,
  input  logic                     ce_hi_n,
  input  logic                     oe_n,
  input  logic                     we_n,
  input  logic                     reg_n,
  input  logic                     a0,
  input  logic [PAIR_W-1:0]        pair,
  input  logic [LANE_W-1:0]        lo_in,
  input  logic [LANE_W-1:0]        hi_in,
  output logic [LANE_W-1:0]        lo_out,
  output logic [LANE_W-1:0]        hi_out,
  output logic                     lo_oe,
  output logic                     hi_oe,
  output logic [SEG_N-1:0]         seg_sel,
  output logic [SEG_N-1:0]         seg_we,
  output logic [LANE_W-1:0]        even_wdata,
  output logic [LANE_W-1:0]        odd_wdata,
  input  logic [PAIRS*LANE_W-1:0]  even_rdata,
  input  logic [PAIRS*LANE_W-1:0]  odd_rdata,
  output logic                     attr_sel,
  output logic                     attr_we,
  output logic [LANE_W-1:0]        attr_wdata,
  input  logic [LANE_W-1:0]        attr_rdata
);

  logic ce_lo_q, ce_hi_q, oe_q, we_q, reg_q, a0_q;
  logic [PAIR_W-1:0] pair_q;
  logic [LANE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_lo_q <= 1'b1;
      ce_hi_q <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      reg_q   <= 1'b1;
      a0_q    <= 1'b0;
      pair_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      ce_lo_q <= ce_lo_n;
      ce_hi_q <= ce_hi_n;
      oe_q    <= oe_n;
      we_q    <= we_n;
      reg_q   <= reg_n;
      a0_q    <= a0;
      pair_q  <= pair;
      lo_q    <= lo_in;
      hi_q    <= hi_in;
    end
  end

  logic byte_lo, odd_only, word, common, attr, rd, wr;
  logic even_need, odd_need, attr_even;

  assign byte_lo   = !ce_lo_q &  ce_hi_q;
  assign odd_only  =  ce_lo_q & !ce_hi_q;
  assign word      = !ce_lo_q & !ce_hi_q;
  assign common    = reg_q & !(ce_lo_q & ce_hi_q);
  assign attr      = !reg_q & !ce_lo_q;
  assign rd        = !oe_q & we_q;
  assign wr        = oe_q & !we_q;
  assign even_need = common & (word | (byte_lo & !a0_q));
  assign odd_need  = common & (word | odd_only | (byte_lo & a0_q));
  assign attr_even = word | !a0_q;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign seg_sel[2*p]   = even_need & (pair_q == PAIR_W'(p));
    assign seg_sel[2*p+1] = odd_need  & (pair_q == PAIR_W'(p));
  end

  assign seg_we = seg_sel & {SEG_N{wr}};

  logic [LANE_W-1:0] even_rd, odd_rd;
  always_comb begin
    even_rd = '0;
    odd_rd  = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (pair_q == PAIR_W'(p)) begin
        even_rd = even_rdata[p*LANE_W +: LANE_W];
        odd_rd  = odd_rdata[p*LANE_W +: LANE_W];
      end
    end
  end

  assign lo_out = attr ? (attr_even ? attr_rdata : FILL)
                       : ((byte_lo & a0_q) ? odd_rd : even_rd);
  assign hi_out = odd_rd;
  assign lo_oe  = rd & (byte_lo | word);
  assign hi_oe  = rd & reg_q & (word | odd_only);

  assign even_wdata = lo_q;
  assign odd_wdata  = byte_lo ? lo_q : hi_q;
  assign attr_wdata = lo_q;
  assign attr_sel   = attr;
  assign attr_we    = attr & wr & attr_even;

  p_no_drive_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> (!lo_oe && !hi_oe));

  p_no_store_on_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_q && !oe_q) |-> (seg_we == '0 && !attr_we));

  p_oe_high_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (!lo_oe && !hi_oe));

  p_standby_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_q && ce_hi_q) |-> (seg_sel == '0 && !attr_sel && !lo_oe && !hi_oe));

  p_byte_one_seg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_q ^ ce_hi_q) |-> $onehot0(seg_sel));

  p_word_two_seg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_sel) <= 2);

  p_attr_low_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q |-> (!hi_oe && seg_sel == '0));

  p_odd_attr_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_q && byte_lo && a0_q) |-> !attr_we);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (seg_sel == '0 && !lo_oe && !hi_oe && !attr_sel));

endmodule

// File: tb/pc_card_steer_test.sv
module pc_card_steer_test;
  localparam int LW = 8;
  localparam int NP = 2;
  localparam int NR = 16;
  localparam logic [LW-1:0] FILLV = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reg_n = 1'b1, a0 = 1'b0;
  logic [0:0] pair = '0;
  logic [LW-1:0] lo_in = '0, hi_in = '0;
  logic [LW-1:0] lo_out, hi_out, even_wdata, odd_wdata, attr_wdata, attr_rdata;
  logic lo_oe, hi_oe, attr_sel, attr_we;
  logic [2*NP-1:0] seg_sel, seg_we;
  logic [NP*LW-1:0] even_rdata, odd_rdata;

  logic [3:0] row = '0, row_q;
  logic [LW-1:0] even_mem [NP][NR];
  logic [LW-1:0] odd_mem  [NP][NR];
  logic [LW-1:0] attr_mem [NR];
  logic [LW-1:0] even_sh  [NP][NR];
  logic [LW-1:0] odd_sh   [NP][NR];
  logic [LW-1:0] attr_sh  [NR];

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_card_steer #(.LANE_W(LW), .PAIRS(NP), .FILL(FILLV)) uut (
    .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n),
    .we_n(we_n), .reg_n(reg_n), .a0(a0), .pair(pair), .lo_in(lo_in), .hi_in(hi_in),
    .lo_out(lo_out), .hi_out(hi_out), .lo_oe(lo_oe), .hi_oe(hi_oe),
    .seg_sel(seg_sel), .seg_we(seg_we), .even_wdata(even_wdata), .odd_wdata(odd_wdata),
    .even_rdata(even_rdata), .odd_rdata(odd_rdata), .attr_sel(attr_sel),
    .attr_we(attr_we), .attr_wdata(attr_wdata), .attr_rdata(attr_rdata));

  function automatic logic [LW-1:0] pat(int kind, int p, int r);
    return LW'(kind * 64 + p * 32 + r);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      for (int p = 0; p < NP; p++)
        for (int r = 0; r < NR; r++) begin
          even_mem[p][r] <= pat(0, p, r);
          odd_mem[p][r]  <= pat(1, p, r);
        end
      for (int r = 0; r < NR; r++) attr_mem[r] <= pat(2, 0, r);
    end else begin
      row_q <= row;
      for (int p = 0; p < NP; p++) begin
        if (seg_we[2*p])   even_mem[p][row_q] <= even_wdata;
        if (seg_we[2*p+1]) odd_mem[p][row_q]  <= odd_wdata;
      end
      if (attr_we) attr_mem[row_q] <= attr_wdata;
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      even_rdata[p*LW +: LW] = even_mem[p][row_q];
      odd_rdata[p*LW +: LW]  = odd_mem[p][row_q];
    end
    attr_rdata = attr_mem[row_q];
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic acc(bit c1, bit c2, bit oe, bit we, bit rg, bit ad, int pr,
                     logic [LW-1:0] lo, logic [LW-1:0] hi, int r);
    bit byte_lo, odd_only, word, com, attr, rd, wr, attr_even;
    logic [2*NP-1:0] esel, ewe;
    logic [LW-1:0] elo;
    string tag;
    ce_lo_n = c1; ce_hi_n = c2; oe_n = oe; we_n = we; reg_n = rg; a0 = ad;
    pair = 1'(pr); lo_in = lo; hi_in = hi; row = 4'(r);
    @(negedge clk);
    byte_lo = !c1 && c2;
    odd_only = c1 && !c2;
    word = !c1 && !c2;
    com = rg && !(c1 && c2);
    attr = !rg && !c1;
    rd = !oe && we;
    wr = oe && !we;
    attr_even = word || !ad;
    if (c1 && c2) tag = "R6";
    else if (attr || !rg) tag = "R10";
    else if (word) tag = "R5";
    else if (odd_only) tag = "R4";
    else if (ad) tag = "R3";
    else tag = "R2";
    esel = '0;
    if (com && (word || (byte_lo && !ad))) esel[2*pr] = 1'b1;
    if (com && (word || odd_only || (byte_lo && ad))) esel[2*pr+1] = 1'b1;
    ewe = wr ? esel : '0;
    chk({tag, " R9"}, "seg_sel", 32'(seg_sel), 32'(esel));
    chk({tag, " R8"}, "seg_we", 32'(seg_we), 32'(ewe));
    chk(tag, "attr_sel", 32'(attr_sel), 32'(attr));
    chk({tag, " R8"}, "attr_we", 32'(attr_we), 32'(attr && wr && attr_even));
    chk({tag, " R7 R8"}, "lo_oe", 32'(lo_oe), 32'(rd && (byte_lo || word)));
    chk({tag, " R7 R8"}, "hi_oe", 32'(hi_oe), 32'(rd && rg && (word || odd_only)));
    if (rd && (byte_lo || word)) begin
      if (attr) elo = attr_even ? attr_sh[r] : FILLV;
      else if (byte_lo && ad) elo = odd_sh[pr][r];
      else elo = even_sh[pr][r];
      chk(tag, "lo_out", 32'(lo_out), 32'(elo));
    end
    if (rd && rg && (word || odd_only))
      chk(tag, "hi_out", 32'(hi_out), 32'(odd_sh[pr][r]));
    if (ewe[2*pr]) begin
      chk(tag, "even_wdata", 32'(even_wdata), 32'(lo));
      even_sh[pr][r] = lo;
    end
    if (ewe[2*pr+1]) begin
      chk(tag, "odd_wdata", 32'(odd_wdata), 32'(byte_lo ? lo : hi));
      odd_sh[pr][r] = byte_lo ? lo : hi;
    end
    if (attr && wr && attr_even) begin
      chk(tag, "attr_wdata", 32'(attr_wdata), 32'(lo));
      attr_sh[r] = lo;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) begin
        even_sh[p][r] = pat(0, p, r);
        odd_sh[p][r]  = pat(1, p, r);
      end
    for (int r = 0; r < NR; r++) attr_sh[r] = pat(2, 0, r);

    repeat (3) @(negedge clk);
    // R1: idle outputs while reset is held
    chk("R1", "reset seg_sel", 32'(seg_sel), 0);
    chk("R1", "reset oe", 32'({lo_oe, hi_oe, attr_sel}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset seg_we", 32'({seg_we, attr_we}), 0);
    chk("R1", "post-reset lanes", 32'({lo_oe, hi_oe}), 0);

    // R5 word writes in both pairs, then R2/R3 byte reads with crossover
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < 4; r++) acc(0, 0, 1, 0, 1, 1, p, 8'(8'hA0 + r), 8'(8'hB0 + r + p), r);
    for (int r = 0; r < 4; r++) begin
      acc(0, 1, 0, 1, 1, 0, 1, 0, 0, r);   // R2
      acc(0, 1, 0, 1, 1, 1, 1, 0, 0, r);   // R3
      acc(1, 0, 0, 1, 1, 0, 0, 0, 0, r);   // R4
    end
    // R3 odd byte write through low lane, R4 odd-only write through high lane
    acc(0, 1, 1, 0, 1, 1, 0, 8'h3C, 8'hEE, 5);
    acc(0, 0, 0, 1, 1, 0, 0, 0, 0, 5);
    acc(1, 0, 1, 0, 1, 0, 1, 8'h11, 8'h5A, 6);
    acc(0, 0, 0, 1, 1, 1, 1, 0, 0, 6);
    acc(0, 1, 1, 0, 1, 0, 1, 8'h77, 8'h99, 7);   // R2 even byte write
    acc(0, 0, 0, 1, 1, 0, 1, 0, 0, 7);
    // R6 standby, R7 OE high, R8 both low
    acc(1, 1, 0, 1, 1, 0, 0, 0, 0, 2);
    acc(1, 1, 1, 0, 1, 0, 0, 8'h42, 8'h43, 2);
    acc(0, 0, 1, 1, 1, 0, 0, 0, 0, 2);
    acc(0, 0, 0, 0, 1, 0, 0, 8'hC3, 8'hC4, 2);
    acc(0, 0, 0, 1, 1, 0, 0, 0, 0, 2);
    // R10 attribute even write, odd write ignored, reads
    acc(0, 1, 1, 0, 0, 0, 0, 8'hD1, 8'h00, 9);
    acc(0, 1, 1, 0, 0, 1, 0, 8'hD2, 8'h00, 9);
    acc(0, 1, 0, 1, 0, 0, 0, 0, 0, 9);
    acc(0, 1, 0, 1, 0, 1, 0, 0, 0, 9);
    acc(0, 0, 0, 1, 0, 1, 1, 0, 0, 9);
    acc(1, 0, 0, 1, 0, 0, 0, 0, 0, 9);
    acc(1, 0, 1, 0, 0, 0, 0, 8'hD3, 8'hD4, 9);
    acc(0, 1, 0, 1, 0, 0, 0, 0, 0, 9);

    for (int i = 0; i < 2000; i++)
      acc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, NP - 1)), 8'($urandom), 8'($urandom),
          int'($urandom_range(0, NR - 1)));

    // final readback sweep over every row in every mode
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) begin
        acc(0, 0, 0, 1, 1, 0, p, 0, 0, r);
        acc(0, 1, 0, 1, 1, 1, p, 0, 0, r);
        acc(0, 1, 0, 1, 0, 0, p, 0, 0, r);
      end
    finish_run();
  end
endmodule